// File: doc/BRIEF.md
# Command Issue Stall Controller

This block decides, cycle by cycle, whether a command engine may start its next instruction. It decodes writes to a small control register, keeps a set of sticky stall flags, and combines them with live busy conditions into a single `issue_ok` permission.

A stop request does not abort the instruction already running. It is parked in a pending flag, and it becomes a real stop stall only when the engine reports that its transfer state is idle. Error and interrupt stalls can each be masked. A cancel write releases a stalled engine. A reset write clears every flag and pulses a request to clear the engine's instruction pointer. The block also compares the graphics interface's 2-bit active-path field against the path the engine needs. That check, like the unit-busy input, is evaluated fresh every cycle and never latched.

Top module: `issue_stall_ctrl`

## Requirements
- R1: After `rst_n` is released, all flags and `soft_rst` are 0 and `issue_ok` is 1 (when `unit_busy` is 0 and `path_chk` is 0).
- R2: A control write with bit 2 set (stop request) sets only `stop_pending` on the next edge. `stop_stall` stays 0 for as long as `xfer_state` is not 0 (0 is the idle code). A pending stop alone does not block issue while the engine is not idle.
- R3: While `stop_pending` is 1 and `xfer_state` is 0, `issue_ok` is 0 in that same cycle. On the next edge `stop_stall` becomes 1 and `stop_pending` becomes 0.
- R4: A control write with bit 1 set (force-break) sets `brk_stall` on the next edge, and `issue_ok` is 0 while it is set.
- R5: One-cycle pulses on `err0_ev`, `err1_ev` and `int_ev` set `err0_flag`, `err1_flag` and `int_flag`. Each set flag blocks issue unless its mask bit is 1 (`stall_mask` bit 0 masks error-0, bit 1 masks error-1, bit 2 masks interrupt).
- R6: A control write with bit 3 set (cancel) clears error-0, error-1, interrupt, pending-stop, stop-stall and force-break flags. An event pulse in the same cycle still sets its flag.
- R7: When stop request and cancel are written together, the cancel is applied first, so `stop_pending` is 1 afterwards.
- R8: A control write with bit 0 set (reset) clears every flag on the next edge. This wins over all other bits of the same write and over event pulses in the same cycle. `soft_rst` is 1 for exactly that one following cycle.
- R9: `path_stall` is 1 exactly when `path_chk` is non-zero and equals `gif_status[11:10]`. It is combinational and blocks issue only while it holds.
- R10: `unit_busy` blocks issue in the same cycle and leaves no flag set.
- R11: In a cycle with no control write, no event pulse and no pending-to-stop conversion, all flags keep their values. A blocked engine therefore changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 4 | Control bits: 0 reset, 1 force-break, 2 stop, 3 cancel |
| xfer_state | input | 2 | Engine transfer state, 0 = idle |
| err0_ev | input | 1 | Error-0 event pulse |
| err1_ev | input | 1 | Error-1 event pulse |
| int_ev | input | 1 | Interrupt-stall event pulse |
| stall_mask | input | 3 | Mask for error-0, error-1 and interrupt stalls |
| gif_status | input | 16 | Graphics interface status; bits 11:10 hold the active path |
| path_chk | input | 2 | Path the engine needs (1..3), 0 = no check |
| unit_busy | input | 1 | Downstream unit busy |
| issue_ok | output | 1 | Engine may issue this cycle |
| stop_stall | output | 1 | Stop stall flag |
| stop_pending | output | 1 | Deferred stop request |
| brk_stall | output | 1 | Force-break stall flag |
| err0_flag | output | 1 | Error-0 flag |
| err1_flag | output | 1 | Error-1 flag |
| int_flag | output | 1 | Interrupt-stall flag |
| path_stall | output | 1 | Active-path conflict this cycle |
| soft_rst | output | 1 | One-cycle request to clear engine state |

## Verification
The bench sweeps every combination of mask and error/interrupt flags, and every combination of active-path field and requested path. A wrong mask polarity, or comparing against the wrong path code, shows up as a wrong `issue_ok`.

The stop deferral is tested with the engine busy, so a design that stalls at once would show `stop_stall` early. The bench also checks the same-cycle block at the idle point, which a purely registered design would miss.

Combined writes are covered as well. A reset that loses to set bits leaves flags behind. A cancel applied after the stop bit loses the request. A cancel that beats a simultaneous event drops the error.

// File: rtl/issue_stall_pkg.sv
package issue_stall_pkg;
    localparam int CTL_W     = 4;
    localparam int CB_RST    = 0;
    localparam int CB_BRK    = 1;
    localparam int CB_STOP   = 2;
    localparam int CB_CANCEL = 3;

    typedef struct packed {
        logic rst;
        logic brk;
        logic stop;
        logic cancel;
    } ctl_cmd_t;

    typedef struct packed {
        logic brk;
        logic stop;
        logic pend;
        logic err0;
        logic err1;
        logic intr;
        logic srst;
    } flags_t;
endpackage

// File: rtl/isc_ctl_decode.sv
module isc_ctl_decode
    import issue_stall_pkg::*;
(
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_data,
    output ctl_cmd_t         cmd
);
    always_comb begin
        cmd        = '0;
        cmd.rst    = ctl_wr & ctl_data[CB_RST];
        cmd.brk    = ctl_wr & ctl_data[CB_BRK];
        cmd.stop   = ctl_wr & ctl_data[CB_STOP];
        cmd.cancel = ctl_wr & ctl_data[CB_CANCEL];
    end
endmodule

// File: rtl/isc_path_check.sv
module isc_path_check #(
    parameter int PATH_W = 2
) (
    input  logic [PATH_W-1:0] path_field,
    input  logic [PATH_W-1:0] path_chk,
    output logic              path_stall
);
    localparam int NPATH = (1 << PATH_W) - 1;
    logic [NPATH:1] hit;

    for (genvar p = 1; p <= NPATH; p++) begin : g_path
        assign hit[p] = (path_chk == PATH_W'(p)) && (path_field == PATH_W'(p));
    end

    assign path_stall = |hit;
endmodule

// File: rtl/isc_flag_core.sv
module isc_flag_core
    import issue_stall_pkg::*;
#(
    parameter int               STATE_W   = 2,
    parameter logic [STATE_W-1:0] IDLE_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_cmd_t           cmd,
    input  logic [STATE_W-1:0] xfer_state,
    input  logic               err0_ev,
    input  logic               err1_ev,
    input  logic               int_ev,
    output flags_t             flags,
    output logic               stop_now
);
    flags_t st_d, st_q;
    logic   idle;

    assign idle     = (xfer_state == IDLE_CODE);
    assign stop_now = st_q.pend & idle;

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        if (stop_now) begin
            st_d.pend = 1'b0;
            st_d.stop = 1'b1;
        end
        if (cmd.cancel) begin
            st_d.brk  = 1'b0;
            st_d.stop = 1'b0;
            st_d.pend = 1'b0;
            st_d.err0 = 1'b0;
            st_d.err1 = 1'b0;
            st_d.intr = 1'b0;
        end
        if (err0_ev)  st_d.err0 = 1'b1;
        if (err1_ev)  st_d.err1 = 1'b1;
        if (int_ev)   st_d.intr = 1'b1;
        if (cmd.brk)  st_d.brk  = 1'b1;
        if (cmd.stop) st_d.pend = 1'b1;
        if (cmd.rst) begin
            st_d      = '0;
            st_d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q;

    p_stop_only_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cmd.rst) && $rose(st_q.stop)) |-> $past(st_q.pend && idle));

    p_stop_request_defers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.stop && !cmd.rst) |=> st_q.pend);

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rst |=> (st_q.srst && !st_q.brk && !st_q.stop && !st_q.pend
                     && !st_q.err0 && !st_q.err1 && !st_q.intr));

    p_cancel_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.cancel && !cmd.rst && !cmd.brk && !cmd.stop && !err0_ev && !err1_ev && !int_ev)
        |=> !(st_q.brk | st_q.stop | st_q.pend | st_q.err0 | st_q.err1 | st_q.intr));

    p_hold_when_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == '0 && !err0_ev && !err1_ev && !int_ev && !stop_now)
        |=> $stable({st_q.brk, st_q.stop, st_q.pend, st_q.err0, st_q.err1, st_q.intr}));
endmodule

// File: rtl/issue_stall_ctrl.sv
module issue_stall_ctrl
    import issue_stall_pkg::*;
#(
    parameter int STATE_W = 2,
    parameter int PATH_W  = 2,
    parameter int STAT_W  = 16,
    parameter int PATH_LO = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_data,
    input  logic [STATE_W-1:0] xfer_state,
    input  logic               err0_ev,
    input  logic               err1_ev,
    input  logic               int_ev,
    input  logic [2:0]         stall_mask,
    input  logic [STAT_W-1:0]  gif_status,
    input  logic [PATH_W-1:0]  path_chk,
    input  logic               unit_busy,
    output logic               issue_ok,
    output logic               stop_stall,
    output logic               stop_pending,
    output logic               brk_stall,
    output logic               err0_flag,
    output logic               err1_flag,
    output logic               int_flag,
    output logic               path_stall,
    output logic               soft_rst
);
    localparam int PATH_HI = PATH_LO + PATH_W - 1;

    ctl_cmd_t cmd;
    flags_t   flags;
    logic     stop_now;
    logic     masked_stall;

    isc_ctl_decode u_dec (
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .cmd      (cmd)
    );

    isc_flag_core #(.STATE_W(STATE_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .xfer_state (xfer_state),
        .err0_ev    (err0_ev),
        .err1_ev    (err1_ev),
        .int_ev     (int_ev),
        .flags      (flags),
        .stop_now   (stop_now)
    );

    isc_path_check #(.PATH_W(PATH_W)) u_path (
        .path_field (gif_status[PATH_HI:PATH_LO]),
        .path_chk   (path_chk),
        .path_stall (path_stall)
    );

    assign masked_stall = (flags.err0 & ~stall_mask[0])
                        | (flags.err1 & ~stall_mask[1])
                        | (flags.intr & ~stall_mask[2]);

    assign issue_ok = ~(flags.brk | flags.stop | stop_now | masked_stall
                        | path_stall | unit_busy);

    assign stop_stall   = flags.stop;
    assign stop_pending = flags.pend;
    assign brk_stall    = flags.brk;
    assign err0_flag    = flags.err0;
    assign err1_flag    = flags.err1;
    assign int_flag     = flags.intr;
    assign soft_rst     = flags.srst;

    p_break_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_stall |-> !issue_ok);

    p_path_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        path_stall |-> !issue_ok);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unit_busy |-> !issue_ok);

    p_srst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !$past(ctl_wr && ctl_data[CB_RST], 2)) |=> !soft_rst);
endmodule

// File: tb/tb_issue_stall_ctrl.sv
module tb_issue_stall_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_data = '0;
    logic [1:0]  xfer_state = 2'd1;
    logic        err0_ev = 1'b0, err1_ev = 1'b0, int_ev = 1'b0;
    logic [2:0]  stall_mask = '0;
    logic [15:0] gif_status = '0;
    logic [1:0]  path_chk = '0;
    logic        unit_busy = 1'b0;
    logic        issue_ok, stop_stall, stop_pending, brk_stall;
    logic        err0_flag, err1_flag, int_flag, path_stall, soft_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    issue_stall_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .xfer_state(xfer_state), .err0_ev(err0_ev), .err1_ev(err1_ev),
        .int_ev(int_ev), .stall_mask(stall_mask), .gif_status(gif_status),
        .path_chk(path_chk), .unit_busy(unit_busy), .issue_ok(issue_ok),
        .stop_stall(stop_stall), .stop_pending(stop_pending),
        .brk_stall(brk_stall), .err0_flag(err0_flag), .err1_flag(err1_flag),
        .int_flag(int_flag), .path_stall(path_stall), .soft_rst(soft_rst)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic chk_flags(input logic [5:0] exp, input string what);
        n_chk++;
        if ({brk_stall, stop_stall, stop_pending, err0_flag, err1_flag, int_flag} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what,
                {brk_stall, stop_stall, stop_pending, err0_flag, err1_flag, int_flag}, exp);
        end
    endtask

    // Pulse a control write for one edge; returns at the next negedge.
    task automatic wr(input logic [3:0] d);
        ctl_wr = 1'b1; ctl_data = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_data = '0;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        chk_flags(6'b0, "R1 flags after reset");
        chk(issue_ok, 1'b1, "R1 issue_ok after reset");
        chk(soft_rst, 1'b0, "R1 soft_rst after reset");

        // R2: stop deferred while busy
        xfer_state = 2'd2;
        wr(4'b0100);
        chk_flags(6'b001000, "R2 stop pending only");
        chk(issue_ok, 1'b1, "R2 pending does not block busy engine");
        repeat (3) @(negedge clk);
        #1 chk(stop_stall, 1'b0, "R2 no stall while busy");
        // R3: idle point converts
        @(negedge clk); xfer_state = 2'd0; #1;
        chk(issue_ok, 1'b0, "R3 blocked at conversion cycle");
        chk(stop_pending, 1'b1, "R3 pending before edge");
        @(negedge clk); #1;
        chk_flags(6'b010000, "R3 stop_stall set pending cleared");
        chk(issue_ok, 1'b0, "R3 stop blocks issue");
        // R11: held while stalled
        repeat (4) @(negedge clk);
        #1 chk_flags(6'b010000, "R11 flags stable while blocked");
        // R6
        wr(4'b1000);
        chk_flags(6'b0, "R6 cancel clears stop");
        chk(issue_ok, 1'b1, "R6 issue resumes");

        // R4
        xfer_state = 2'd1;
        wr(4'b0010);
        chk(brk_stall, 1'b1, "R4 break set");
        chk(issue_ok, 1'b0, "R4 break blocks");
        wr(4'b1000);
        chk(brk_stall, 1'b0, "R6 cancel clears break");

        // R7
        wr(4'b1100);
        chk_flags(6'b001000, "R7 stop survives same-write cancel");
        wr(4'b1000);

        // R6 event with cancel
        err0_ev = 1'b1; wr(4'b0000); err0_ev = 1'b0;
        err1_ev = 1'b1; wr(4'b1000); err1_ev = 1'b0;
        chk_flags(6'b000010, "R6 event beats cancel");
        wr(4'b1000);

        // R5 sweep
        for (int m = 0; m < 8; m++) begin
            for (int f = 1; f < 8; f++) begin
                stall_mask = 3'(m);
                err0_ev = f[0]; err1_ev = f[1]; int_ev = f[2];
                @(negedge clk);
                err0_ev = 1'b0; err1_ev = 1'b0; int_ev = 1'b0;
                #1;
                chk_flags({3'b000, f[0], f[1], f[2]}, "R5 flags from events");
                chk(issue_ok, ((f & ~m) & 7) == 0, "R5 masked issue");
                wr(4'b1000);
                chk_flags(6'b0, "R6 cancel clears error flags");
            end
        end
        stall_mask = '0;

        // R8: reset write wins
        err0_ev = 1'b1; int_ev = 1'b1;
        wr(4'b0111);
        err0_ev = 1'b0; int_ev = 1'b0;
        chk_flags(6'b0, "R8 reset write wins");
        chk(soft_rst, 1'b1, "R8 soft_rst pulse");
        @(negedge clk); #1;
        chk(soft_rst, 1'b0, "R8 soft_rst one cycle");

        // R9 sweep
        for (int fld = 0; fld < 4; fld++) begin
            for (int c = 0; c < 4; c++) begin
                gif_status = 16'h0000 | (16'(fld) << 10) | 16'hF3FF;
                path_chk = 2'(c);
                @(negedge clk); #1;
                chk(path_stall, (c != 0) && (fld == c), "R9 path compare");
                chk(issue_ok, !((c != 0) && (fld == c)), "R9 path issue");
                chk_flags(6'b0, "R9 path not latched");
            end
        end
        path_chk = '0;

        // R10
        unit_busy = 1'b1; #1;
        chk(issue_ok, 1'b0, "R10 busy blocks");
        @(negedge clk); unit_busy = 1'b0; #1;
        chk(issue_ok, 1'b1, "R10 busy not latched");
        chk_flags(6'b0, "R10 no flag left");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule